// File: doc/BRIEF.md
# Dual-Request Programmable Interrupt Controller

This block takes 32 interrupt sources and drives two interrupt request lines and a wake line. Software programs each source on its own. It chooses a trigger mode, picks which of the two request lines the source drives, turns the source on or off with a mask bit, and can let the source raise the wake line. The trigger mode is a three-bit code split across three separate configuration words. Two instances can be placed side by side to cover 64 sources.

Software reaches every control word through a simple register bus. A write to the set view ORs the write data into the word, and a write to the clear view removes the bits that are one in the data. The read view returns the word. Every source input passes through a two-flop synchroniser. Edges are caught in sticky rising and falling status words that software clears by writing ones. Level sources are not latched. Each request line has a readable pending word, and the line is the OR of that word.

Top module: `intc_dual_req`

## Requirements
- R1: After reset, every readable word is zero and `req0_o`, `req1_o` and `wake_o` are low. So every source starts disabled, masked and routed to request line 1.
- R2: The bus address is `{group[3:0], view[1:0]}`. View 0 reads, view 1 sets the bits that are one in the data, and view 2 clears them. Zero data bits leave a word unchanged. The groups are: 0, 1 and 2 for trigger bit 0, 1 and 2; 3 source select; 4 route; 5 wake; 6 mask; 7 rising status; 8 falling status; 9 pending word of line 0; 10 pending word of line 1; 11 diagnostic word.
- R3: The trigger code of a source is {group2 bit, group1 bit, group0 bit}. 001 is rising edge, 010 is falling edge, 011 is either edge, 101 is active-high level and 110 is active-low level.
- R4: A rising edge of the synchronised input sets the source's rising status bit when the code is 001 or 011. A falling edge sets the falling status bit when the code is 010 or 011. Status bits stay set until software writes a one to the clear view of that status group. In either-edge mode, both status bits must be cleared before the source stops being active.
- R5: A level source is not latched. It is active exactly while its synchronised input is 1 (code 101) or 0 (code 110).
- R6: Codes 000, 100 and 111 never make a source active and never set a status bit.
- R7: A source appears in a pending word only while its mask bit is 1.
- R8: A source whose route bit is 1 appears in pending word 0. A source whose route bit is 0 appears in pending word 1. Each request line is the OR of its pending word.
- R9: `wake_o` is high while any active source has its wake bit set, whatever its mask bit is.
- R10: An input change reaches the level-driven pending state after exactly two rising clock edges.
- R11: The diagnostic word is loaded directly by any write to group 11 with view 1, and it reads back unchanged. Holding it at zero has no effect on operation. The source select word is read and written like the other control words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Group (bits 5:2) and view (bits 1:0) |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Read data of the addressed group |
| src_in | input | 32 | Asynchronous source inputs |
| req0_o | output | 1 | Interrupt request line 0 |
| req1_o | output | 1 | Interrupt request line 1 |
| wake_o | output | 1 | Wake request |

## Verification
Some checks run on every cycle:
- Unwritten control bits keep their value.
- A status bit rises only after a qualifying edge, and a cleared bit stays clear unless a new edge arrives.
- No source shows in both pending words.
- No masked source is pending, and both request lines are low while the mask word is zero.

Other behaviour only the directed scenarios can show:
- the decoding of each trigger code, including the invalid ones;
- the split between the two request lines;
- the two-edge synchroniser latency;
- wake while masked;
- the need to clear both status bits of an either-edge source.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int GRP_W  = 4;
  localparam int VIEW_W = 2;
  localparam int N_CTRL = 7;

  localparam logic [GRP_W-1:0] G_TRIG0 = 4'd0;
  localparam logic [GRP_W-1:0] G_MASK  = 4'd6;
  localparam logic [GRP_W-1:0] G_RISE  = 4'd7;
  localparam logic [GRP_W-1:0] G_FALL  = 4'd8;
  localparam logic [GRP_W-1:0] G_PEND0 = 4'd9;
  localparam logic [GRP_W-1:0] G_PEND1 = 4'd10;
  localparam logic [GRP_W-1:0] G_DIAG  = 4'd11;

  localparam logic [VIEW_W-1:0] V_READ = 2'd0;
  localparam logic [VIEW_W-1:0] V_SET  = 2'd1;
  localparam logic [VIEW_W-1:0] V_CLR  = 2'd2;

  // Status latching enables, derived from the trigger code planes
  function automatic logic rise_mode(logic [2:0] code);
    return code == 3'b001 || code == 3'b011;
  endfunction

  function automatic logic fall_mode(logic [2:0] code);
    return code == 3'b010 || code == 3'b011;
  endfunction

  // Activity of one source from its code, synced level and status bits
  function automatic logic src_active(logic [2:0] code, logic lvl,
                                      logic rst, logic fst);
    case (code)
      3'b001:  return rst;
      3'b010:  return fst;
      3'b011:  return rst | fst;
      3'b101:  return lvl;
      3'b110:  return ~lvl;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/intc_alias_reg.sv
module intc_alias_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;

  assert_hold_unwritten_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(set_i | clr_i)) & (q ^ $past(q))) == '0);
endmodule

// File: rtl/intc_edge.sv
module intc_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] rise_clr_i,
  input  logic [W-1:0] fall_clr_i,
  output logic [W-1:0] rise_st_o,
  output logic [W-1:0] fall_st_o
);
  logic [W-1:0] prev_q, rise_st, fall_st;
  logic [W-1:0] ev_rise, ev_fall;

  assign ev_rise = sync_i & ~prev_q & rise_en_i;
  assign ev_fall = ~sync_i & prev_q & fall_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      rise_st <= '0;
      fall_st <= '0;
    end else begin
      prev_q  <= sync_i;
      rise_st <= (rise_st & ~rise_clr_i) | ev_rise;
      fall_st <= (fall_st & ~fall_clr_i) | ev_fall;
    end
  end

  assign rise_st_o = rise_st;
  assign fall_st_o = fall_st;

  assert_rise_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_st & ~$past(rise_st) & ~$past(ev_rise)) == '0);
  assert_fall_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_st & ~$past(fall_st) & ~$past(ev_fall)) == '0);
  assert_rise_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_st & $past(rise_clr_i & ~ev_rise)) == '0);
  assert_fall_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_st & $past(fall_clr_i & ~ev_fall)) == '0);
endmodule

// File: rtl/intc_dual_req.sv
module intc_dual_req
  import intc_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = GRP_W + VIEW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            req0_o,
  output logic            req1_o,
  output logic            wake_o
);
  localparam int G_ROUTE_IDX = 4;
  localparam int G_WAKE_IDX  = 5;
  localparam int G_MASK_IDX  = 6;

  logic [GRP_W-1:0]  grp;
  logic [VIEW_W-1:0] view;
  logic [NSRC-1:0]   ctrl_q [N_CTRL];
  logic [NSRC-1:0]   sync_lvl, rise_st, fall_st, active;
  logic [NSRC-1:0]   rise_en, fall_en, pend0, pend1, diag_q;
  logic [NSRC-1:0]   rise_clr, fall_clr;

  assign grp  = bus_addr[AW-1:VIEW_W];
  assign view = bus_addr[VIEW_W-1:0];

  // Control planes: trigger bits 0..2, source select, route, wake, mask
  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    logic [NSRC-1:0] set_w, clr_w;
    assign set_w = (bus_we && grp == GRP_W'(g) && view == V_SET) ? bus_wdata : '0;
    assign clr_w = (bus_we && grp == GRP_W'(g) && view == V_CLR) ? bus_wdata : '0;
    intc_alias_reg #(.W(NSRC)) u_plane (
      .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .q_o(ctrl_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     diag_q <= '0;
    else if (bus_we && grp == G_DIAG && view == V_SET) diag_q <= bus_wdata;
  end

  intc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_in), .sync_o(sync_lvl)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [2:0] code;
    assign code      = {ctrl_q[2][i], ctrl_q[1][i], ctrl_q[0][i]};
    assign rise_en[i] = rise_mode(code);
    assign fall_en[i] = fall_mode(code);
    assign active[i]  = src_active(code, sync_lvl[i], rise_st[i], fall_st[i]);
  end

  assign rise_clr = (bus_we && grp == G_RISE && view == V_CLR) ? bus_wdata : '0;
  assign fall_clr = (bus_we && grp == G_FALL && view == V_CLR) ? bus_wdata : '0;

  intc_edge #(.W(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_lvl),
    .rise_en_i(rise_en), .fall_en_i(fall_en),
    .rise_clr_i(rise_clr), .fall_clr_i(fall_clr),
    .rise_st_o(rise_st), .fall_st_o(fall_st)
  );

  assign pend0  = active & ctrl_q[G_MASK_IDX] & ctrl_q[G_ROUTE_IDX];
  assign pend1  = active & ctrl_q[G_MASK_IDX] & ~ctrl_q[G_ROUTE_IDX];
  assign req0_o = |pend0;
  assign req1_o = |pend1;
  assign wake_o = |(active & ctrl_q[G_WAKE_IDX]);

  always_comb begin
    if (grp < GRP_W'(N_CTRL)) bus_rdata = ctrl_q[grp[2:0]];
    else begin
      case (grp)
        G_RISE:  bus_rdata = rise_st;
        G_FALL:  bus_rdata = fall_st;
        G_PEND0: bus_rdata = pend0;
        G_PEND1: bus_rdata = pend1;
        G_DIAG:  bus_rdata = diag_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_route_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 & pend1) == '0);
  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0 | pend1) & ~ctrl_q[G_MASK_IDX]) == '0);
  assert_no_req_all_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[G_MASK_IDX] == '0) |-> (!req0_o && !req1_o));
  assert_level_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_en | fall_en) == '0 && $stable(sync_lvl) && $stable(ctrl_q[2])
     && $stable(ctrl_q[1]) && $stable(ctrl_q[0])) |-> $stable(active));
endmodule

// File: tb/intc_dual_req_bench.sv
module intc_dual_req_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic        req0_o, req1_o, wake_o;
  int          n_chk = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  intc_dual_req u_intc_dual_req (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int g, int v, logic [31:0] d);
    @(negedge clk);
    bus_addr = {g[3:0], v[1:0]}; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(int g, output logic [31:0] d);
    @(negedge clk);
    bus_addr = {g[3:0], 2'd0};
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // code c on source s, route r, mask m
  task automatic setup_src(int s, logic [2:0] c, bit r, bit m);
    for (int p = 0; p < 3; p++) wr(p, c[p] ? 1 : 2, 32'h1 << s);
    wr(4, r ? 1 : 2, 32'h1 << s);
    wr(6, m ? 1 : 2, 32'h1 << s);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int g = 0; g < 12; g++) begin
      rd(g, d);
      chk($sformatf("R1 group %0d reset", g), d, 32'h0);
    end
    chk("R1 request/wake lines at reset", {29'h0, req0_o, req1_o, wake_o}, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    wr(0, 1, 32'h0000_FFFF);
    wr(0, 1, 32'h00FF_0000);
    rd(0, d); chk("R2 set accumulates", d, 32'h00FF_FFFF);
    wr(0, 2, 32'h0000_F00F);
    rd(0, d); chk("R2 clear removes ones", d, 32'h00FF_0FF0);
    wr(0, 1, 32'h0); wr(0, 2, 32'h0);
    rd(0, d); chk("R2 zero data no change", d, 32'h00FF_0FF0);
    wr(0, 2, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 full clear", d, 32'h0);
    wr(3, 1, 32'hA5A5_0001);
    rd(3, d); chk("R11 source select readback", d, 32'hA5A5_0001);
    wr(3, 2, 32'hFFFF_FFFF);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    setup_src(3, 3'b001, 1'b1, 1'b1);
    src_in[3] = 1'b1; settle();
    rd(7, d); chk("R4 rising status set", d, 32'h8);
    rd(9, d); chk("R8 pending word 0", d, 32'h8);
    chk("R8 line0 high line1 low", {30'h0, req0_o, req1_o}, 32'h2);
    src_in[3] = 1'b0; settle();
    rd(7, d); chk("R4 status sticky after input low", d, 32'h8);
    rd(8, d); chk("R3 rising mode ignores fall", d, 32'h0);
    wr(7, 2, 32'h8); settle();
    rd(7, d); chk("R4 W1C rising", d, 32'h0);
    chk("R8 line0 drops after clear", {31'h0, req0_o}, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    setup_src(5, 3'b010, 1'b0, 1'b1);
    src_in[5] = 1'b1; settle();
    rd(8, d); chk("R3 falling mode ignores rise", d, 32'h0);
    src_in[5] = 1'b0; settle();
    rd(8, d); chk("R4 falling status set", d, 32'h20);
    rd(10, d); chk("R8 route 0 to pending word 1", d, 32'h20);
    chk("R8 line1 high line0 low", {30'h0, req0_o, req1_o}, 32'h1);
    wr(8, 2, 32'h20);
  endtask

  task automatic t_either();
    logic [31:0] d;
    setup_src(7, 3'b011, 1'b1, 1'b1);
    src_in[7] = 1'b1; settle(); src_in[7] = 1'b0; settle();
    rd(7, d); chk("R4 either edge rising bit", d, 32'h80);
    rd(8, d); chk("R4 either edge falling bit", d, 32'h80);
    wr(7, 2, 32'h80); settle();
    chk("R4 still pending with fall bit", {31'h0, req0_o}, 32'h1);
    wr(8, 2, 32'h80); settle();
    chk("R4 idle after both cleared", {31'h0, req0_o}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    setup_src(9, 3'b101, 1'b1, 1'b1);
    src_in[9] = 1'b1; settle();
    rd(9, d); chk("R5 active-high pending", d, 32'h200);
    src_in[9] = 1'b0; settle();
    rd(9, d); chk("R5 level not latched", d, 32'h0);
    rd(7, d); chk("R5 no status from level", d, 32'h0);
    setup_src(10, 3'b110, 1'b0, 1'b1); settle();
    rd(10, d); chk("R5 active-low pending with input low", d, 32'h400);
    src_in[10] = 1'b1; settle();
    rd(10, d); chk("R5 active-low released", d, 32'h0);
  endtask

  task automatic t_invalid();
    logic [31:0] d;
    setup_src(11, 3'b100, 1'b1, 1'b1);
    setup_src(12, 3'b111, 1'b1, 1'b1);
    setup_src(13, 3'b000, 1'b1, 1'b1);
    src_in[13:11] = 3'b111; settle();
    rd(9, d); chk("R6 invalid codes high input", d, 32'h0);
    src_in[13:11] = 3'b000; settle();
    rd(9, d); chk("R6 invalid codes low input", d, 32'h0);
    rd(7, d); chk("R6 no rising status", d, 32'h0);
    rd(8, d); chk("R6 no falling status", d, 32'h0);
  endtask

  task automatic t_mask_wake();
    logic [31:0] d;
    setup_src(15, 3'b001, 1'b1, 1'b0);
    wr(5, 1, 32'h8000);
    src_in[15] = 1'b1; settle();
    rd(9, d); chk("R7 masked source not pending", d, 32'h0);
    chk("R9 wake while masked", {31'h0, wake_o}, 32'h1);
    wr(6, 1, 32'h8000);
    rd(9, d); chk("R7 unmask reveals latched event", d, 32'h8000);
    wr(6, 2, 32'h8000);
    rd(9, d); chk("R7 remask hides it", d, 32'h0);
    wr(5, 2, 32'h8000);
    chk("R9 wake off with wake bit clear", {31'h0, wake_o}, 32'h0);
    wr(7, 2, 32'h8000); src_in[15] = 1'b0;
  endtask

  task automatic t_latency();
    setup_src(20, 3'b101, 1'b0, 1'b1); settle();
    @(negedge clk); src_in[20] = 1'b1;
    @(negedge clk); chk("R10 not visible after one edge", {31'h0, req1_o}, 32'h0);
    @(negedge clk); chk("R10 visible after two edges", {31'h0, req1_o}, 32'h1);
    src_in[20] = 1'b0; settle();
  endtask

  task automatic t_diag();
    logic [31:0] d;
    wr(11, 1, 32'h0000_0001);
    rd(11, d); chk("R11 diag readback", d, 32'h1);
    wr(11, 1, 32'h0);
    rd(11, d); chk("R11 diag back to zero", d, 32'h0);
    setup_src(21, 3'b001, 1'b1, 1'b1);
    src_in[21] = 1'b1; settle();
    rd(9, d); chk("R11 normal operation with diag zero", d, 32'h0020_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alias();
    t_rise();
    t_fall();
    t_either();
    t_level();
    t_invalid();
    t_mask_wake();
    t_latency();
    t_diag();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule